// File: doc/BRIEF.md
# Dual-Convention Multiplexed Bus Slave Front End

This block sits between a processor's multiplexed address/data bus and the register file of a small peripheral. An address strobe captures the address from the shared bus lines. A data phase then follows, and the block turns it into a single-cycle read-enable or write-enable pulse toward the register file, together with the captured address and the write data. During a qualified read it also drives the register data back onto the bus.

A static mode input selects one of two strobe conventions on the same pins:

- **Mode high:** a data strobe qualifies a direction level.
- **Mode low:** the two pins act as separate active-low read and write strobes, like a plain static RAM.

Every strobe and level is synchronized to the system clock before it is decoded. An access reaches the register file only when all three gates allow it: chip select is active, the power-fail input is clear, and the bus reset input is high. A cycle without chip select still updates the captured address.

Top module: `mbus_front`

## Requirements
- R1: With `mode_i`=1, a data phase with `dstb_i`=1 and `dir_i`=1 is a read. A qualified read gives exactly one `reg_rd_o` pulse, one clock long, with `reg_addr_o` holding the captured address.
- R2: With `mode_i`=1, `dir_i`=0 while `dstb_i`=1 is a write. After `dstb_i` falls, exactly one `reg_wr_o` pulse is issued, and `reg_wdata_o` carries the bus value present during the phase.
- R3: With `mode_i`=0, `dstb_i` is an active-low read strobe. A qualified low period gives exactly one `reg_rd_o` pulse.
- R4: With `mode_i`=0, `dir_i` is an active-low write strobe. One `reg_wr_o` pulse is issued after it returns high, carrying the bus data.
- R5: On the falling edge of `ale_i`, `reg_addr_o` is loaded from the low AW bits of `ad_i`. It holds that value until the next falling edge of `ale_i`, including across data phases that have no address strobe.
- R6: A data phase with `cs_n_i`=1 issues no read or write pulse and does not enable the bus driver, but its address strobe still updates `reg_addr_o`.
- R7: A write during which `cs_n_i` goes high before the strobe ends issues no write pulse.
- R8: While `pwr_fail_i`=1, no read or write pulse is issued and `ad_oe_o` stays 0.
- R9: While `bus_rst_n_i`=0, no access pulse is issued. Once it returns to 1, accesses work again.
- R10: `ad_oe_o` is 1 only within a qualified read data phase, with `ad_o` equal to the register data returned for the captured address. It returns to 0 after the phase ends.
- R11: `reg_rd_o` and `reg_wr_o` are never 1 together, and each pulse lasts a single clock.
- R12: After the synchronous reset `rst`, `reg_rd_o`, `reg_wr_o`, `ad_oe_o` and `reg_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 1: strobe plus direction; 0: separate active-low strobes |
| ale_i | input | 1 | Address strobe, address captured on its falling edge |
| dstb_i | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| dir_i | input | 1 | Direction, 1 = read (mode 1), or active-low write strobe (mode 0) |
| cs_n_i | input | 1 | Active-low chip select |
| pwr_fail_i | input | 1 | Power-fail indication, blocks access when 1 |
| bus_rst_n_i | input | 1 | Active-low reset input, blocks access when 0 |
| ad_i | input | DW | Multiplexed address/data bus, input side |
| ad_o | output | DW | Read data driven onto the bus |
| ad_oe_o | output | 1 | Bus driver enable |
| reg_addr_o | output | AW | Captured register address |
| reg_rd_o | output | 1 | Single-cycle read enable to the register file |
| reg_wr_o | output | 1 | Single-cycle write enable to the register file |
| reg_wdata_o | output | DW | Write data to the register file |
| reg_rdata_i | input | DW | Read data returned by the register file |

## Verification
The bench runs both conventions back to back, because a decode that mixes them up would turn a mode-low read strobe into a write, or would treat the idle levels as a data phase. It runs an address strobe with chip select inactive and then a data phase with no address strobe. A design that gates the address latch with chip select, or that reloads the address on every phase, would show the wrong address. Chip select is withdrawn in the middle of a write, which catches a design that issues the write on the trailing edge without remembering that qualification was lost. Power fail and the bus reset input are each held during full read and write cycles, where a missed gate would show up as a pulse or as an enabled driver.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic {
        MODE_SEP_STROBES = 1'b0,
        MODE_STROBE_DIR  = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } phase_t;

    // Bit positions inside the control synchronizer vector
    localparam int CTL_ALE  = 0;
    localparam int CTL_DSTB = 1;
    localparam int CTL_DIR  = 2;
    localparam int CTL_CSN  = 3;
    localparam int CTL_PF   = 4;
    localparam int CTL_BRN  = 5;
    localparam int CTL_W    = 6;

    // Idle values loaded into the synchronizers by reset
    localparam logic [CTL_W-1:0] CTL_IDLE = 6'b001100;

    function automatic phase_t decode_phase(bus_mode_e mode, logic dstb, logic dir);
        phase_t p;
        if (mode == MODE_STROBE_DIR) begin
            p.rd = dstb & dir;
            p.wr = dstb & ~dir;
        end else begin
            p.wr = ~dir;
            p.rd = ~dstb & dir;
        end
        return p;
    endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e mode,
    input  logic      dstb_s,
    input  logic      dir_s,
    input  logic      cs_n_s,
    input  logic      pf_s,
    input  logic      brn_s,
    output logic      rd_pulse,
    output logic      wr_pulse,
    output logic      wr_phase,
    output logic      oe
);
    phase_t ph;
    logic   qual;
    logic   rd_prev, wr_prev;
    logic   rd_start, wr_start, wr_end;
    logic   wr_ok, rd_act;

    always_comb begin
        ph       = decode_phase(mode, dstb_s, dir_s);
        qual     = ~cs_n_s & ~pf_s & brn_s;
        rd_start = ph.rd & ~rd_prev;
        wr_start = ph.wr & ~wr_prev;
        wr_end   = ~ph.wr & wr_prev;
    end

    assign wr_phase = ph.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev  <= 1'b0;
            wr_prev  <= 1'b0;
            wr_ok    <= 1'b0;
            rd_act   <= 1'b0;
            rd_pulse <= 1'b0;
            wr_pulse <= 1'b0;
            oe       <= 1'b0;
        end else begin
            rd_prev  <= ph.rd;
            wr_prev  <= ph.wr;
            rd_pulse <= rd_start & qual;
            wr_pulse <= wr_end & wr_ok & qual;

            // Write stays armed only if qualified for the whole phase
            if (wr_start)            wr_ok <= qual;
            else if (ph.wr && !qual) wr_ok <= 1'b0;
            else if (wr_end)         wr_ok <= 1'b0;

            if (rd_start && qual)       rd_act <= 1'b1;
            else if (!ph.rd || !qual)   rd_act <= 1'b0;

            oe <= rd_act & ph.rd & qual;
        end
    end
endmodule

// File: rtl/mbus_front.sv
module mbus_front
    import mbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_i,
    input  logic          ale_i,
    input  logic          dstb_i,
    input  logic          dir_i,
    input  logic          cs_n_i,
    input  logic          pwr_fail_i,
    input  logic          bus_rst_n_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic [AW-1:0] reg_addr_o,
    output logic          reg_rd_o,
    output logic          reg_wr_o,
    output logic [DW-1:0] reg_wdata_o,
    input  logic [DW-1:0] reg_rdata_i
);
    localparam int ADDR_LSB = 0;

    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic [DW-1:0]    ad_s;
    logic             ale_s, ale_prev, ale_fall;
    logic             cs_n_s, pf_s, brn_s;
    logic             wr_phase;
    logic [DW-1:0]    rd_hold, wd_hold;
    logic [AW-1:0]    addr_q;
    bus_mode_e        mode;

    assign mode = bus_mode_e'(mode_i);

    always_comb begin
        ctl_raw           = '0;
        ctl_raw[CTL_ALE]  = ale_i;
        ctl_raw[CTL_DSTB] = dstb_i;
        ctl_raw[CTL_DIR]  = dir_i;
        ctl_raw[CTL_CSN]  = cs_n_i;
        ctl_raw[CTL_PF]   = pwr_fail_i;
        ctl_raw[CTL_BRN]  = bus_rst_n_i;
    end

    mbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    mbus_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
        .clk(clk), .rst(rst), .d(ad_i), .q(ad_s)
    );

    assign ale_s  = ctl_s[CTL_ALE];
    assign cs_n_s = ctl_s[CTL_CSN];
    assign pf_s   = ctl_s[CTL_PF];
    assign brn_s  = ctl_s[CTL_BRN];
    assign ale_fall = ale_prev & ~ale_s;

    mbus_decode u_dec (
        .clk(clk), .rst(rst), .mode(mode),
        .dstb_s(ctl_s[CTL_DSTB]), .dir_s(ctl_s[CTL_DIR]),
        .cs_n_s(cs_n_s), .pf_s(pf_s), .brn_s(brn_s),
        .rd_pulse(reg_rd_o), .wr_pulse(reg_wr_o),
        .wr_phase(wr_phase), .oe(ad_oe_o)
    );

    // Address latch: no chip-select gating, by intent
    always_ff @(posedge clk) begin
        if (rst) begin
            ale_prev <= 1'b0;
            addr_q   <= '0;
        end else begin
            ale_prev <= ale_s;
            if (ale_fall) addr_q <= ad_s[ADDR_LSB +: AW];
        end
    end

    // Data holding registers for both directions
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hold <= '0;
            wd_hold <= '0;
        end else begin
            if (wr_phase) wd_hold <= ad_s;
            if (reg_rd_o) rd_hold <= reg_rdata_i;
        end
    end

    assign reg_addr_o  = addr_q;
    assign reg_wdata_o = wd_hold;
    assign ad_o        = rd_hold;
endmodule

// File: rtl/mbus_front_chk.sv
module mbus_front_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_rd_o,
    input logic          reg_wr_o,
    input logic          ad_oe_o,
    input logic [AW-1:0] reg_addr_o,
    input logic          cs_n_s,
    input logic          pf_s,
    input logic          brn_s,
    input logic          ale_fall
);
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_rd_o |=> !reg_rd_o); // R11
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) reg_wr_o |=> !reg_wr_o); // R11
    AST_NO_RD_AND_WR: assert property (@(posedge clk) disable iff (rst) !(reg_rd_o && reg_wr_o)); // R11
    AST_ACC_NEEDS_CS: assert property (@(posedge clk) disable iff (rst) (reg_rd_o || reg_wr_o) |-> !$past(cs_n_s)); // R6
    AST_PF_BLOCKS:    assert property (@(posedge clk) disable iff (rst) (reg_rd_o || reg_wr_o || ad_oe_o) |-> !$past(pf_s)); // R8
    AST_RST_BLOCKS:   assert property (@(posedge clk) disable iff (rst) (reg_rd_o || reg_wr_o) |-> $past(brn_s)); // R9
    AST_ADDR_HELD:    assert property (@(posedge clk) disable iff (rst) !ale_fall |=> $stable(reg_addr_o)); // R5
endmodule

bind mbus_front mbus_front_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
    .ad_oe_o(ad_oe_o), .reg_addr_o(reg_addr_o), .cs_n_s(cs_n_s),
    .pf_s(pf_s), .brn_s(brn_s), .ale_fall(ale_fall)
);

// File: tb/tb_mbus_front.sv
module tb_mbus_front;
    localparam int DW = 8;
    localparam int AW = 7;

    logic clk = 1'b0;
    logic rst;
    logic mode_i, ale_i, dstb_i, dir_i, cs_n_i, pwr_fail_i, bus_rst_n_i;
    logic [DW-1:0] ad_i, ad_o, reg_wdata_o, reg_rdata_i;
    logic ad_oe_o, reg_rd_o, reg_wr_o;
    logic [AW-1:0] reg_addr_o;

    int checks = 0;
    int failures = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int oe_cnt = 0;
    int both_cnt = 0;
    logic [DW-1:0] last_wdata = '0;
    logic [DW-1:0] last_oe_data = '0;
    logic [AW-1:0] exp_addr = '0;
    bit done = 0;

    always #10 clk = ~clk;

    mbus_front #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .ale_i(ale_i), .dstb_i(dstb_i),
        .dir_i(dir_i), .cs_n_i(cs_n_i), .pwr_fail_i(pwr_fail_i),
        .bus_rst_n_i(bus_rst_n_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
        .reg_addr_o(reg_addr_o), .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o),
        .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
    );

    // Register file model: data depends on address
    assign reg_rdata_i = 8'hA0 ^ {1'b0, reg_addr_o};

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_rd_o) rd_cnt++;
            if (reg_wr_o) begin wr_cnt++; last_wdata = reg_wdata_o; end
            if (reg_rd_o && reg_wr_o) both_cnt++;
            if (ad_oe_o) begin oe_cnt++; last_oe_data = ad_o; end
        end
    end

    task automatic check(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(bit md);
        @(negedge clk);
        mode_i = md;
        dstb_i = md ? 1'b0 : 1'b1;
        dir_i  = 1'b1;
        cs_n_i = 1'b1;
        wait_cyc(6);
    endtask

    // One complete bus cycle with the given qualifiers, checked afterwards
    task automatic bus_cycle(string req, bit wr, bit skip_ale, logic [DW-1:0] a,
                             logic [DW-1:0] d, bit csn, bit pf, bit brn,
                             bit drop_cs, int exp_rd, int exp_wr);
        int rd0, wr0, oe0;
        rd0 = rd_cnt; wr0 = wr_cnt; oe0 = oe_cnt;
        @(negedge clk);
        if (!skip_ale) begin
            ad_i = a; ale_i = 1'b1;
            wait_cyc(4);
            ale_i = 1'b0;
            wait_cyc(4);
            exp_addr = a[AW-1:0];
        end
        cs_n_i = csn; pwr_fail_i = pf; bus_rst_n_i = brn;
        wait_cyc(3);
        if (mode_i) begin
            dir_i = ~wr; dstb_i = 1'b1;
        end else if (wr) dir_i = 1'b0;
        else dstb_i = 1'b0;
        if (wr) ad_i = d;
        wait_cyc(6);
        if (drop_cs) begin cs_n_i = 1'b1; wait_cyc(4); end
        dstb_i = mode_i ? 1'b0 : 1'b1;
        dir_i = 1'b1;
        wait_cyc(6);
        cs_n_i = 1'b1; pwr_fail_i = 1'b0; ad_i = '0;
        wait_cyc(4);
        check({req, " read pulses"}, rd_cnt - rd0 == exp_rd, rd_cnt - rd0, exp_rd);
        check({req, " write pulses"}, wr_cnt - wr0 == exp_wr, wr_cnt - wr0, exp_wr);
        check({req, " address"}, reg_addr_o == exp_addr, reg_addr_o, exp_addr);
        if (exp_rd > 0) begin
            check({req, " R10 oe during read"}, oe_cnt > oe0, oe_cnt - oe0, 1);
            check({req, " R10 read data"}, last_oe_data == (8'hA0 ^ {1'b0, exp_addr}),
                  last_oe_data, 8'hA0 ^ {1'b0, exp_addr});
        end else begin
            check({req, " R10 no oe"}, oe_cnt == oe0, oe_cnt - oe0, 0);
        end
        if (exp_wr > 0)
            check({req, " write data"}, last_wdata == d, last_wdata, d);
        check({req, " R10 oe released"}, ad_oe_o == 1'b0, ad_oe_o, 0);
    endtask

    task automatic t_reset;
        check("R12 rd", reg_rd_o == 1'b0, reg_rd_o, 0);
        check("R12 wr", reg_wr_o == 1'b0, reg_wr_o, 0);
        check("R12 oe", ad_oe_o == 1'b0, ad_oe_o, 0);
        check("R12 addr", reg_addr_o == '0, reg_addr_o, 0);
    endtask

    task automatic t_strobe_dir;
        set_mode(1'b1);
        bus_cycle("R1 R5", 0, 0, 8'hD5, 8'h00, 0, 0, 1, 0, 1, 0);
        bus_cycle("R2", 1, 0, 8'h2A, 8'h5C, 0, 0, 1, 0, 0, 1);
    endtask

    task automatic t_sep_strobes;
        set_mode(1'b0);
        bus_cycle("R3", 0, 0, 8'h33, 8'h00, 0, 0, 1, 0, 1, 0);
        bus_cycle("R4", 1, 0, 8'h41, 8'h9E, 0, 0, 1, 0, 0, 1);
    endtask

    task automatic t_no_cs;
        set_mode(1'b1);
        bus_cycle("R6", 0, 0, 8'h7F, 8'h00, 1, 0, 1, 0, 0, 0);
        bus_cycle("R6 write", 1, 0, 8'h12, 8'hEE, 1, 0, 1, 0, 0, 0);
        bus_cycle("R5 hold", 0, 1, 8'h00, 8'h00, 0, 0, 1, 0, 1, 0);
    endtask

    task automatic t_cs_drop;
        set_mode(1'b1);
        bus_cycle("R7", 1, 0, 8'h05, 8'h77, 0, 0, 1, 1, 0, 0);
        set_mode(1'b0);
        bus_cycle("R7 sep", 1, 0, 8'h06, 8'h78, 0, 0, 1, 1, 0, 0);
    endtask

    task automatic t_power_fail;
        set_mode(1'b1);
        bus_cycle("R8 read", 0, 0, 8'h10, 8'h00, 0, 1, 1, 0, 0, 0);
        bus_cycle("R8 write", 1, 0, 8'h11, 8'h3C, 0, 1, 1, 0, 0, 0);
    endtask

    task automatic t_bus_reset;
        set_mode(1'b0);
        bus_cycle("R9 read", 0, 0, 8'h20, 8'h00, 0, 0, 0, 0, 0, 0);
        bus_cycle("R9 write", 1, 0, 8'h21, 8'h44, 0, 0, 0, 0, 0, 0);
        bus_rst_n_i = 1'b1;
        wait_cyc(4);
        bus_cycle("R9 resume", 0, 0, 8'h22, 8'h00, 0, 0, 1, 0, 1, 0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_i = 1'b1; ale_i = 1'b0; dstb_i = 1'b0; dir_i = 1'b1;
        cs_n_i = 1'b1; pwr_fail_i = 1'b0; bus_rst_n_i = 1'b1; ad_i = '0;
        wait_cyc(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_strobe_dir();
        t_sep_strobes();
        t_no_cs();
        t_cs_drop();
        t_power_fail();
        t_bus_reset();
        check("R11 never both", both_cnt == 0, both_cnt, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule